// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It keeps two component predictors of different kinds. The first is a global predictor whose two-bit counters are addressed by the shared outcome history of recent branches. The second is a two-level local predictor: a per-branch history table, indexed by PC, whose entry addresses a table of three-bit counters. A third table of two-bit selector counters, addressed by the global history, decides which of the two components supplies the final answer.

The fetch port takes a branch PC and returns the final prediction together with both component predictions, combinationally and in the same cycle. The fetch stage keeps the two component bits with the branch. When the branch resolves, the resolve port carries the PC, the real outcome and those two recorded bits. On that clock edge every table and both histories are trained. Branches are expected to resolve in order. No history repair after a flush is done.

Top module: `tournament_predictor`

## Requirements
- R1: While `rst_n` is low, and after it rises, the global history and every local history entry are zero. Every two-bit counter holds 1 and every three-bit counter holds 3. All three fetch outputs therefore read 0 for any PC.
- R2: The global history is `GHIST_W` bits wide. Bit 0 is the most recent outcome, bit i is the outcome i+1 branches back, and a 1 means taken. The history itself (no PC bits) is the index into the global counter table.
- R3: A two-bit counter covers 0..3 and saturates at both ends. It predicts taken at 2 or 3, so a strongly set counter needs two opposite outcomes in a row before its prediction flips.
- R4: The local history table has 2^`LHT_IDX_W` entries, selected by PC bits `[ALIGN +: LHT_IDX_W]`. Each entry is `LHIST_W` bits, newest outcome in bit 0. The entry is the index into a table of three-bit counters, and `fe_lpred` is that counter's top bit. A fixed loop pattern that is no longer than the local history is eventually predicted without error.
- R5: A three-bit counter covers 0..7, saturates at both ends and counts up on taken and down on not taken.
- R6: The selector counter at the current global history picks the source of `fe_taken`. Values 2 and 3 select the global bit and values 0 and 1 select the local bit.
- R7: The selector counter changes only on a resolve whose `rs_gpred` and `rs_lpred` differ. It moves up by one, saturating, if `rs_gpred` equals `rs_taken`, and otherwise moves down by one.
- R8: On a resolve, the global counter at the pre-update global history and the local counter at the pre-update local history of `rs_pc` are both trained toward `rs_taken`. On the same edge, `rs_taken` is shifted into the global history and into the local entry of `rs_pc`.
- R9: The fetch outputs are combinational in `fe_pc` and the stored state. A fetch in the same cycle as a resolve sees the state from before that resolve.
- R10: A cycle with `rs_valid` low leaves all predictor state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| fe_pc | input | PC_W | PC of the branch being fetched |
| fe_taken | output | 1 | Final direction prediction |
| fe_gpred | output | 1 | Global component prediction |
| fe_lpred | output | 1 | Local component prediction |
| rs_valid | input | 1 | A branch resolves this cycle |
| rs_pc | input | PC_W | PC of the resolving branch |
| rs_taken | input | 1 | Real outcome of the resolving branch |
| rs_gpred | input | 1 | Global prediction recorded at fetch |
| rs_lpred | input | 1 | Local prediction recorded at fetch |

## Verification
The bench goes after these corner cases:
- **Counter saturation at both ends.** A counter that wrapped would throw a strongly trained branch to the opposite prediction.
- **Selector training on agreement.** A selector that also moved when both components agreed would drift toward one side, and later picks would come out wrong.
- **Fetch and resolve in the same cycle.** A design that forwarded the resolving outcome into the fetch read would predict from a history one step ahead.
- **Repeating four-branch loop.** Only a correct local history with its newest bit in position 0 learns this loop without error.

A small configuration is swept for thousands of cycles with random PCs, outcomes, recorded component bits and resolve gaps. Each fetch output is compared with an arithmetic model of the tables.

// File: rtl/tp_pkg.sv
package tp_pkg;

    // Which component supplies the final prediction.
    typedef enum logic {
        SRC_LOCAL  = 1'b0,
        SRC_GLOBAL = 1'b1
    } tp_src_e;

    // Weakly-not-taken value for a counter of the given width.
    function automatic int unsigned weak_nt(input int unsigned w);
        return (1 << (w - 1)) - 1;
    endfunction

endpackage

// File: rtl/tp_ctr_bank.sv
module tp_ctr_bank #(
    parameter int unsigned IDX_W = 12,
    parameter int unsigned CTR_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_msb,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_up
);
    localparam int unsigned      DEPTH   = 1 << IDX_W;
    localparam logic [CTR_W-1:0] CTR_MAX = '1;
    localparam logic [CTR_W-1:0] CTR_RST = CTR_W'(tp_pkg::weak_nt(CTR_W));

    logic [CTR_W-1:0] ctr_q [DEPTH];
    logic [CTR_W-1:0] cur;

    assign rd_msb = ctr_q[rd_idx][CTR_W-1];
    assign cur    = ctr_q[wr_idx];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                ctr_q[i] <= CTR_RST;
            end
        end else if (wr_en) begin
            if (wr_up && cur != CTR_MAX) begin
                ctr_q[wr_idx] <= cur + 1'b1;
            end else if (!wr_up && cur != '0) begin
                ctr_q[wr_idx] <= cur - 1'b1;
            end
        end
    end
endmodule

// File: rtl/tp_lhist_table.sv
module tp_lhist_table #(
    parameter int unsigned IDX_W  = 10,
    parameter int unsigned HIST_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  fe_idx,
    output logic [HIST_W-1:0] fe_hist,
    input  logic [IDX_W-1:0]  rs_idx,
    output logic [HIST_W-1:0] rs_hist,
    input  logic              wr_en,
    input  logic              wr_bit
);
    localparam int unsigned DEPTH = 1 << IDX_W;

    logic [HIST_W-1:0] hist_q [DEPTH];

    assign fe_hist = hist_q[fe_idx];
    assign rs_hist = hist_q[rs_idx];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                hist_q[i] <= '0;
            end
        end else if (wr_en) begin
            hist_q[rs_idx] <= {rs_hist[HIST_W-2:0], wr_bit};
        end
    end
endmodule

// File: rtl/tournament_predictor.sv
module tournament_predictor #(
    parameter int unsigned PC_W      = 32,
    parameter int unsigned ALIGN     = 2,
    parameter int unsigned GHIST_W   = 12,
    parameter int unsigned LHT_IDX_W = 10,
    parameter int unsigned LHIST_W   = 10,
    parameter int unsigned GCTR_W    = 2,
    parameter int unsigned LCTR_W    = 3,
    parameter int unsigned SEL_W     = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] fe_pc,
    output logic            fe_taken,
    output logic            fe_gpred,
    output logic            fe_lpred,
    input  logic            rs_valid,
    input  logic [PC_W-1:0] rs_pc,
    input  logic            rs_taken,
    input  logic            rs_gpred,
    input  logic            rs_lpred
);
    import tp_pkg::*;

    logic [GHIST_W-1:0]   ghist_q;
    logic [LHT_IDX_W-1:0] fe_slot, rs_slot;
    logic [LHIST_W-1:0]   fe_lhist, rs_lhist;
    logic                 sel_msb;
    logic                 sel_train;
    tp_src_e              src;
    logic                 unused_pc;

    assign fe_slot   = fe_pc[ALIGN +: LHT_IDX_W];
    assign rs_slot   = rs_pc[ALIGN +: LHT_IDX_W];
    assign unused_pc = ^{fe_pc, rs_pc};

    // Shared global outcome history, newest outcome in bit 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ghist_q <= '0;
        end else if (rs_valid) begin
            ghist_q <= {ghist_q[GHIST_W-2:0], rs_taken};
        end
    end

    tp_ctr_bank #(.IDX_W(GHIST_W), .CTR_W(GCTR_W)) u_gbank (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_idx (ghist_q),
        .rd_msb (fe_gpred),
        .wr_en  (rs_valid),
        .wr_idx (ghist_q),
        .wr_up  (rs_taken)
    );

    tp_lhist_table #(.IDX_W(LHT_IDX_W), .HIST_W(LHIST_W)) u_lht (
        .clk     (clk),
        .rst_n   (rst_n),
        .fe_idx  (fe_slot),
        .fe_hist (fe_lhist),
        .rs_idx  (rs_slot),
        .rs_hist (rs_lhist),
        .wr_en   (rs_valid),
        .wr_bit  (rs_taken)
    );

    tp_ctr_bank #(.IDX_W(LHIST_W), .CTR_W(LCTR_W)) u_lbank (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_idx (fe_lhist),
        .rd_msb (fe_lpred),
        .wr_en  (rs_valid),
        .wr_idx (rs_lhist),
        .wr_up  (rs_taken)
    );

    // The selector trains only when the recorded components disagreed.
    assign sel_train = rs_valid && (rs_gpred != rs_lpred);

    tp_ctr_bank #(.IDX_W(GHIST_W), .CTR_W(SEL_W)) u_sbank (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_idx (ghist_q),
        .rd_msb (sel_msb),
        .wr_en  (sel_train),
        .wr_idx (ghist_q),
        .wr_up  (rs_gpred == rs_taken)
    );

    always_comb begin
        src = tp_src_e'(sel_msb);
        unique case (src)
            SRC_GLOBAL: fe_taken = fe_gpred;
            SRC_LOCAL:  fe_taken = fe_lpred;
            default:    fe_taken = fe_lpred;
        endcase
    end
endmodule

// File: rtl/tp_checker.sv
module tp_checker #(
    parameter int unsigned GH_W = 12
) (
    input logic            clk,
    input logic            rst_n,
    input logic            rs_valid,
    input logic            rs_taken,
    input logic            fe_taken,
    input logic            fe_gpred,
    input logic            fe_lpred,
    input logic [GH_W-1:0] ghist
);
    AST_PICK_FROM_PART: assert property (@(posedge clk) disable iff (!rst_n)
        (fe_taken == fe_gpred) || (fe_taken == fe_lpred)) else $error("pick"); // R6

    AST_AGREE_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
        (fe_gpred == fe_lpred) |-> (fe_taken == fe_gpred)) else $error("agree"); // R6

    AST_GHIST_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        rs_valid |=> ghist == {$past(ghist[GH_W-2:0]), $past(rs_taken)}) else $error("shift"); // R8

    AST_GHIST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rs_valid |=> $stable(ghist)) else $error("hold"); // R10

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> ghist == '0) else $error("reset"); // R1
endmodule

bind tournament_predictor tp_checker #(.GH_W(GHIST_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rs_valid (rs_valid),
    .rs_taken (rs_taken),
    .fe_taken (fe_taken),
    .fe_gpred (fe_gpred),
    .fe_lpred (fe_lpred),
    .ghist    (ghist_q)
);

// File: tb/tb_tournament_predictor.sv
`timescale 1ns/1ps
module tb_tournament_predictor;
    localparam int PC_W = 8, ALIGN = 2, GH = 4, LI = 2, LH = 3;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [PC_W-1:0] fe_pc = '0, rs_pc = '0;
    logic            fe_taken, fe_gpred, fe_lpred;
    logic            rs_valid = 1'b0, rs_taken = 1'b0, rs_gpred = 1'b0, rs_lpred = 1'b0;

    int errors = 0, checks = 0;

    // Reference tables of the model.
    int gm [1<<GH];
    int sc [1<<GH];
    int lc [1<<LH];
    int lh [1<<LI];
    int gh;

    always #2.5 clk = ~clk;

    tournament_predictor #(.PC_W(PC_W), .ALIGN(ALIGN), .GHIST_W(GH),
                           .LHT_IDX_W(LI), .LHIST_W(LH)) dut (
        .clk(clk), .rst_n(rst_n), .fe_pc(fe_pc), .fe_taken(fe_taken),
        .fe_gpred(fe_gpred), .fe_lpred(fe_lpred), .rs_valid(rs_valid),
        .rs_pc(rs_pc), .rs_taken(rs_taken), .rs_gpred(rs_gpred), .rs_lpred(rs_lpred));

    task automatic check(input logic got, input logic exp, input string req);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0b expected %0b at %0t", req, got, exp, $time);
        end
    endtask

    function automatic int slot(input logic [PC_W-1:0] pc);
        return int'(pc[ALIGN +: LI]);
    endfunction

    function automatic logic m_gp();
        return gm[gh] >= 2;
    endfunction

    function automatic logic m_lp(input logic [PC_W-1:0] pc);
        return lc[lh[slot(pc)]] >= 4;
    endfunction

    function automatic logic m_fin(input logic [PC_W-1:0] pc);
        return (sc[gh] >= 2) ? m_gp() : m_lp(pc);
    endfunction

    function automatic int sat(input int v, input logic up, input int mx);
        if (up) return (v < mx) ? v + 1 : v;
        return (v > 0) ? v - 1 : v;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < (1<<GH); i++) begin gm[i] = 1; sc[i] = 1; end
        for (int i = 0; i < (1<<LH); i++) lc[i] = 3;
        for (int i = 0; i < (1<<LI); i++) lh[i] = 0;
        gh = 0;
    endtask

    task automatic model_resolve(input logic [PC_W-1:0] pc, input logic tk,
                                 input logic rg, input logic rl);
        int s, li;
        s  = slot(pc);
        li = lh[s];
        gm[gh] = sat(gm[gh], tk, 3);                 // R8
        lc[li] = sat(lc[li], tk, 7);                 // R5
        if (rg != rl) sc[gh] = sat(sc[gh], rg == tk, 3); // R7
        gh    = ((gh << 1) | int'(tk)) & ((1<<GH) - 1);  // R2
        lh[s] = ((lh[s] << 1) | int'(tk)) & ((1<<LH) - 1);
    endtask

    // One cycle: drive at the falling edge, compare before the rising edge.
    task automatic step(input logic [PC_W-1:0] fpc, input logic v,
                        input logic [PC_W-1:0] rpc, input logic tk,
                        input logic rg, input logic rl, input string tag);
        @(negedge clk);
        fe_pc = fpc; rs_valid = v; rs_pc = rpc; rs_taken = tk;
        rs_gpred = rg; rs_lpred = rl;
        #1;
        check(fe_gpred, m_gp(), {tag, " R2 R3 gpred"});
        check(fe_lpred, m_lp(fpc), {tag, " R4 R5 lpred"});
        check(fe_taken, m_fin(fpc), {tag, " R6 R9 taken"});
        if (v) model_resolve(rpc, tk, rg, rl);
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog: got hang expected finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [15:0] lf;
        logic [PC_W-1:0] pa;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1: every PC predicts not taken after reset
        for (int p = 0; p < (1<<PC_W); p += 4) begin
            @(negedge clk); fe_pc = PC_W'(p); #1;
            check(fe_taken, 1'b0, "R1 taken");
            check(fe_gpred, 1'b0, "R1 gpred");
            check(fe_lpred, 1'b0, "R1 lpred");
        end

        // R6 R3 R7: disagreement with global correct moves selector to global
        pa = 8'h24;
        step(pa, 1'b1, pa, 1'b1, 1'b1, 1'b0, "sel");
        for (int k = 0; k < GH; k++) step(pa, 1'b1, pa, 1'b0, 1'b0, 1'b0, "sel");
        @(negedge clk); fe_pc = pa; rs_valid = 1'b0; #1;
        check(fe_gpred, 1'b1, "R3 weak counter flips after one taken");
        check(fe_taken, 1'b1, "R6 R7 selector picks global");

        // R4: repeating loop T T T N on one branch is learned exactly
        rst_n = 1'b0; model_reset();
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
        pa = 8'h14;
        for (int k = 0; k < 80; k++) begin
            logic o;
            o = (k % 4) != 3;
            @(negedge clk);
            fe_pc = pa; rs_valid = 1'b1; rs_pc = pa; rs_taken = o;
            rs_gpred = m_gp(); rs_lpred = m_lp(pa);
            #1;
            check(fe_taken, m_fin(pa), "R4 R9 loop model");
            if (k >= 64) check(fe_taken, o, "R4 loop pattern learned");
            model_resolve(pa, o, rs_gpred, rs_lpred);
        end

        // R5 R3: long run of taken saturates counters; two not-taken flip global
        for (int k = 0; k < 12; k++) step(pa, 1'b1, pa, 1'b1, 1'b1, 1'b1, "sat");
        for (int k = 0; k < 3; k++) step(pa, 1'b1, pa, 1'b0, 1'b1, 1'b1, "sat");

        // R7 R8 R9 R10: random sweep against the model
        lf = 16'hACE1;
        for (int k = 0; k < 4000; k++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            step(PC_W'(lf[7:0]), lf[9] | lf[11], PC_W'({lf[3:0], lf[15:12]}),
                 lf[4] ^ lf[1], lf[5], lf[6], "R7 R8 R10 sweep");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule